// File: doc/BRIEF.md
# Receive-queue drain engine

The block takes data words from a serial receiver into a small receive queue and moves them to a memory-style write port. Software sets it up through four word-wide registers: a control word, a destination base address, a transfer count, and a status word. The control word holds a port enable, a transfer enable and a 4-bit fill threshold.

With the transfer enable clear, the queue is drained by software. A level interrupt reports when the queue holds more words than the threshold. With both enables set, the engine writes queued words to consecutive word addresses, starting at the base address. It counts down the remaining words and pulses a completion interrupt once the count reaches zero.

Clearing the transfer enable pauses the transfer without touching the queue. Setting it again resumes from the saved address and remaining count. Clearing the port enable empties the queue and rewinds the progress to the programmed base and count.

Top module: `rxq_drain`

## Requirements
- R1: After reset every register reads zero, the queue is empty, and `mem_wr_o`, `done_irq_o` and `thresh_irq_o` are low.
- R2: A word offered on `push_valid_i` is stored only while the port enable (control bit 1) is set. Offered words are ignored while it is clear.
- R3: While both enables are set (transfer enable is control bit 0), the remaining count is nonzero and the queue holds a word, `mem_wr_o` is high and carries the oldest queued word at the current address. Each cycle with `mem_ready_i` high pops that word, advances the address by one and lowers the remaining count by one.
- R4: While `mem_ready_i` is low, the address, the remaining count and the queue level all hold.
- R5: `done_irq_o` is high for exactly one cycle, the cycle after the write that takes the remaining count to zero. No further writes follow until a new count is loaded.
- R6: Clearing the transfer enable during a transfer stops memory writes and leaves the queued words and the level unchanged.
- R7: Setting the transfer enable again, with the port still enabled, continues at the saved address and remaining count.
- R8: While the transfer enable is clear, `thresh_irq_o` is high exactly when the queue level is greater than the threshold (control bits 7:4).
- R9: While the transfer enable is set, `thresh_irq_o` stays low whatever the level.
- R10: Writes to the base register (offset 1) or the count register (offset 2) are ignored while the transfer enable is set. While it is clear, such a write also reloads the current address or the remaining count.
- R11: While the port enable is clear, the queue is empty and the current address and remaining count are reloaded from the programmed base and count.
- R12: The queue holds 8 words. A word offered while it is full is dropped and sets the sticky overflow flag (status bit 9). Writing the status register (offset 3) with bit 9 set clears the flag.
- R13: The status register reads the queue level in bits 3:0, the busy flag (both enables set and a nonzero remaining count) in bit 8, the overflow flag in bit 9 and the remaining count in bits 31:16. Control reads back at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset: 0 control, 1 base, 2 count, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| push_valid_i | input | 1 | Receiver offers a word |
| push_data_i | input | 32 | Offered word |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Memory word address |
| mem_data_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |
| done_irq_o | output | 1 | Transfer complete, one-cycle pulse |
| thresh_irq_o | output | 1 | Queue level above threshold while the transfer enable is clear |

## Verification
Register writes, pushes and memory handshakes take effect at the next rising edge. The queue level, `thresh_irq_o` and the status fields change in the cycle after that edge, and `mem_wr_o` rises in the same cycle as the level. `done_irq_o` is due one cycle after the final accepted write. The bench drives every input 1 ns after a rising edge and samples at the following falling edge, so each result is read in the first cycle it is due. A falling-edge monitor compares every accepted write with a bench queue of pushed words and a bench address counter, and expects the completion pulse in the cycle after the write that meets the programmed count.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_BASE  = 2'd1,
    REG_COUNT = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_DMA_BIT  = 0;
  localparam int unsigned CTRL_PORT_BIT = 1;
  localparam int unsigned CTRL_THR_LSB  = 4;
  localparam int unsigned STAT_BUSY_BIT = 8;
  localparam int unsigned STAT_OVF_BIT  = 9;
  localparam int unsigned STAT_REM_LSB  = 16;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  p_pop_nonempty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_flush_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  p_full_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(wr_ptr_q)));
endmodule

// File: rtl/rxq_dma_engine.sv
module rxq_dma_engine #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_en_i,
  input  logic          port_en_i,
  input  logic          ld_addr_i,
  input  logic          ld_cnt_i,
  input  logic [AW-1:0] ld_addr_val_i,
  input  logic [CW-1:0] ld_cnt_val_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          empty_i,
  input  logic          mem_ready_i,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          pop_o,
  output logic [CW-1:0] rem_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic          done_q, step;

  assign busy_o     = dma_en_i && port_en_i && (rem_q != '0);
  assign mem_wr_o   = busy_o && !empty_i;
  assign step       = mem_wr_o && mem_ready_i;
  assign pop_o      = step;
  assign mem_addr_o = addr_q;
  assign rem_o      = rem_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= step && (rem_q == CW'(1));
      if (!port_en_i) begin
        // port off: rewind progress continuously
        addr_q <= base_i;
        rem_q  <= count_i;
      end else if (step) begin
        addr_q <= addr_q + AW'(1);
        rem_q  <= rem_q - CW'(1);
      end else begin
        if (ld_addr_i) addr_q <= ld_addr_val_i;
        if (ld_cnt_i)  rem_q  <= ld_cnt_val_i;
      end
    end
  end

  p_step_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (addr_q == $past(addr_q) + AW'(1)) && (rem_q == $past(rem_q) - CW'(1)));
  p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !mem_ready_i) |=> $stable(addr_q) && $stable(rem_q));
  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rem_q == '0));
  p_port_rewind_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (addr_q == $past(base_i)) && (rem_q == $past(count_i)));
endmodule

// File: rtl/rxq_drain.sv
module rxq_drain
  import rxq_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          push_valid_i,
  input  logic [DW-1:0] push_data_i,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  input  logic          mem_ready_i,
  output logic          done_irq_o,
  output logic          thresh_irq_o
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic          dma_en_q, port_en_q, ovf_q;
  logic [TW-1:0] thr_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] count_q, rem;
  logic [LW-1:0] level;
  logic          full, empty, pop, busy;
  logic          wr_ctrl, wr_base, wr_count, wr_stat;
  reg_sel_e      sel;

  assign sel      = reg_sel_e'(reg_addr_i);
  assign wr_ctrl  = reg_we_i && (sel == REG_CTRL);
  assign wr_base  = reg_we_i && (sel == REG_BASE) && !dma_en_q;
  assign wr_count = reg_we_i && (sel == REG_COUNT) && !dma_en_q;
  assign wr_stat  = reg_we_i && (sel == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_en_q  <= 1'b0;
      port_en_q <= 1'b0;
      thr_q     <= '0;
      base_q    <= '0;
      count_q   <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        dma_en_q  <= reg_wdata_i[CTRL_DMA_BIT];
        port_en_q <= reg_wdata_i[CTRL_PORT_BIT];
        thr_q     <= reg_wdata_i[CTRL_THR_LSB +: TW];
      end
      if (wr_base)  base_q  <= reg_wdata_i[AW-1:0];
      if (wr_count) count_q <= reg_wdata_i[CW-1:0];
      // set wins over a same-cycle clear
      if (push_valid_i && port_en_q && full) ovf_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[STAT_OVF_BIT]) ovf_q <= 1'b0;
    end
  end

  rxq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!port_en_q),
    .push_i  (push_valid_i && port_en_q),
    .pop_i   (pop),
    .data_i  (push_data_i),
    .data_o  (mem_data_o),
    .level_o (level),
    .full_o  (full),
    .empty_o (empty)
  );

  rxq_dma_engine #(.AW(AW), .CW(CW)) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dma_en_i      (dma_en_q),
    .port_en_i     (port_en_q),
    .ld_addr_i     (wr_base),
    .ld_cnt_i      (wr_count),
    .ld_addr_val_i (reg_wdata_i[AW-1:0]),
    .ld_cnt_val_i  (reg_wdata_i[CW-1:0]),
    .base_i        (base_q),
    .count_i       (count_q),
    .empty_i       (empty),
    .mem_ready_i   (mem_ready_i),
    .mem_wr_o      (mem_wr_o),
    .mem_addr_o    (mem_addr_o),
    .pop_o         (pop),
    .rem_o         (rem),
    .busy_o        (busy),
    .done_o        (done_irq_o)
  );

  assign thresh_irq_o = !dma_en_q && (32'(level) > 32'(thr_q));

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      REG_CTRL: begin
        reg_rdata_o[CTRL_DMA_BIT]          = dma_en_q;
        reg_rdata_o[CTRL_PORT_BIT]         = port_en_q;
        reg_rdata_o[CTRL_THR_LSB +: TW]    = thr_q;
      end
      REG_BASE:  reg_rdata_o[AW-1:0] = base_q;
      REG_COUNT: reg_rdata_o[CW-1:0] = count_q;
      default: begin
        reg_rdata_o[LW-1:0]                = level;
        reg_rdata_o[STAT_BUSY_BIT]         = busy;
        reg_rdata_o[STAT_OVF_BIT]          = ovf_q;
        reg_rdata_o[STAT_REM_LSB +: CW]    = rem;
      end
    endcase
  end

  p_port_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_q |=> (level == '0));
  p_thr_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_q |-> !thresh_irq_o);
  p_cfg_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_q |=> $stable(base_q) && $stable(count_q));
  p_ovf_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_stat && reg_wdata_i[STAT_OVF_BIT])) |=> ovf_q);
  p_pause_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_en_q && port_en_q && !push_valid_i) |=> $stable(level));
endmodule

// File: tb/rxq_drain_tb_top.sv
`timescale 1ns/1ps
module rxq_drain_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        mem_wr;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_ready = 1'b0;
  logic        done_irq;
  logic        thresh_irq;

  always #4 clk = ~clk;

  rxq_drain dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .push_valid_i(push_valid),
    .push_data_i(push_data), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .mem_ready_i(mem_ready), .done_irq_o(done_irq),
    .thresh_irq_o(thresh_irq)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;
  bit rand_ready = 1'b0;

  logic [31:0] q_data [0:4095];
  int          q_wr = 0;
  int          q_rd = 0;
  logic [31:0] addr_exp = '0;
  int          xfer_writes = 0;
  int          xfer_target = 0;
  int          done_seen = 0;
  bit          prev_final = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int lvl();
    return q_wr - q_rd;
  endfunction

  function automatic logic [31:0] ctrl_word(input bit dma, input bit port, input logic [3:0] thr);
    return {24'd0, thr, 2'b00, port, dma};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_ready) mem_ready = ($urandom_range(0, 3) != 0);
  end

  // write monitor: data/address order (R3, R7) and completion pulse timing (R5)
  always @(negedge clk) begin
    if (rst_n && !wd_hit) begin
      if (done_irq || prev_final)
        chk(done_irq == prev_final, "R5 done pulse", 32'(done_irq), 32'(prev_final));
      if (done_irq) done_seen++;
      prev_final = 1'b0;
      if (mem_wr && mem_ready) begin
        chk(mem_data == q_data[q_rd[11:0]], "R3 write data", mem_data, q_data[q_rd[11:0]]);
        chk(mem_addr == addr_exp, "R3 R7 write address", mem_addr, addr_exp);
        q_rd++;
        addr_exp = addr_exp + 32'd1;
        xfer_writes++;
        if (xfer_writes == xfer_target) prev_final = 1'b1;
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    tick();
  endtask

  task automatic push(input logic [31:0] d, input bit accept);
    push_valid = 1'b1; push_data = d;
    tick();
    push_valid = 1'b0;
    if (accept) begin
      q_data[q_wr[11:0]] = d;
      q_wr++;
    end
  endtask

  task automatic start_xfer(input logic [31:0] base, input int target);
    addr_exp = base; xfer_writes = 0; xfer_target = target; done_seen = 0;
  endtask

  task automatic wait_writes(input int n);
    for (int i = 0; i < 3000 && xfer_writes < n; i++) tick();
  endtask

  logic [31:0] rd;
  int pushed;
  int cnt;
  logic [31:0] base;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), rd);
      chk(rd == 32'd0, "R1 register reset", rd, 32'd0);
    end
    @(negedge clk);
    chk(!mem_wr && !done_irq && !thresh_irq, "R1 outputs low",
        {29'd0, mem_wr, done_irq, thresh_irq}, 32'd0);
    tick();

    // R2 pushes ignored with port disabled
    push(32'hDEAD0001, 1'b0);
    push(32'hDEAD0002, 1'b0);
    reg_rd(2'd3, rd);
    chk(rd[3:0] == 4'd0, "R2 level with port off", 32'(rd[3:0]), 32'd0);

    // R8 threshold with transfer off, threshold 2
    reg_wr(2'd0, ctrl_word(1'b0, 1'b1, 4'd2));
    for (int i = 0; i < 3; i++) begin
      push(32'hA000_0000 + 32'(i), 1'b1);
      @(negedge clk);
      chk(thresh_irq == (lvl() > 2), "R8 threshold level", 32'(thresh_irq), 32'(lvl() > 2));
      tick();
    end

    // program base 0x100 count 5, R10 readback
    reg_wr(2'd1, 32'h0000_0100);
    reg_wr(2'd2, 32'd5);
    start_xfer(32'h100, 5);

    // R9 / R3 / R4: enable transfer with memory stalled
    mem_ready = 1'b0;
    reg_wr(2'd0, ctrl_word(1'b1, 1'b1, 4'd2));
    @(negedge clk);
    chk(!thresh_irq, "R9 threshold masked", 32'(thresh_irq), 32'd0);
    chk(mem_wr && mem_addr == 32'h100 && mem_data == 32'hA000_0000, "R3 first request",
        mem_addr, 32'h100);
    tick();
    repeat (3) tick();
    reg_rd(2'd3, rd);
    chk(rd[3:0] == 4'd3 && rd[31:16] == 16'd5, "R4 stall holds level/count", rd, 32'h0005_0103);
    chk(rd[8] == 1'b1, "R13 busy flag set", 32'(rd[8]), 32'd1);

    // R10 config writes ignored while enabled
    reg_wr(2'd1, 32'h0000_0999);
    reg_wr(2'd2, 32'd77);
    reg_rd(2'd1, rd);
    chk(rd == 32'h100, "R10 base locked", rd, 32'h100);
    reg_rd(2'd2, rd);
    chk(rd == 32'd5, "R10 count locked", rd, 32'd5);
    reg_rd(2'd3, rd);
    chk(rd[31:16] == 16'd5, "R10 remaining unchanged", 32'(rd[31:16]), 32'd5);

    push(32'hA000_0003, 1'b1);
    push(32'hA000_0004, 1'b1);
    rand_ready = 1'b1;
    wait_writes(3);

    // R6 pause
    reg_wr(2'd0, ctrl_word(1'b0, 1'b1, 4'd2));
    tick();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!mem_wr, "R6 no writes while paused", 32'(mem_wr), 32'd0);
      tick();
    end
    reg_rd(2'd3, rd);
    chk(32'(rd[3:0]) == 32'(lvl()), "R6 level kept", 32'(rd[3:0]), 32'(lvl()));
    chk(32'(rd[31:16]) == 32'(5 - xfer_writes), "R7 remaining saved", 32'(rd[31:16]),
        32'(5 - xfer_writes));
    chk(rd[8] == 1'b0, "R13 busy clear while paused", 32'(rd[8]), 32'd0);

    // R7 resume
    reg_wr(2'd0, ctrl_word(1'b1, 1'b1, 4'd2));
    wait_writes(5);
    repeat (3) tick();
    chk(done_seen == 1, "R5 one completion", 32'(done_seen), 32'd1);
    push(32'hB000_0000, 1'b1);
    tick();
    @(negedge clk);
    chk(!mem_wr, "R5 idle after completion", 32'(mem_wr), 32'd0);
    tick();
    reg_rd(2'd3, rd);
    chk(rd[3:0] == 4'd1, "R5 word kept after completion", 32'(rd[3:0]), 32'd1);

    // R11 port off flushes and rewinds
    reg_wr(2'd0, 32'd0);
    q_rd = q_wr;
    tick();
    reg_rd(2'd3, rd);
    chk(rd[3:0] == 4'd0, "R11 flushed", 32'(rd[3:0]), 32'd0);
    chk(rd[31:16] == 16'd5, "R11 remaining rewound", 32'(rd[31:16]), 32'd5);
    reg_wr(2'd2, 32'd2);
    start_xfer(32'h100, 2);
    reg_wr(2'd0, ctrl_word(1'b0, 1'b1, 4'd0));
    push(32'hC000_0000, 1'b1);
    push(32'hC000_0001, 1'b1);
    reg_wr(2'd0, ctrl_word(1'b1, 1'b1, 4'd0));
    wait_writes(2);
    repeat (3) tick();
    chk(done_seen == 1, "R11 rewound transfer done", 32'(done_seen), 32'd1);

    // R12 overflow
    reg_wr(2'd0, ctrl_word(1'b0, 1'b1, 4'd0));
    for (int i = 0; i < 8; i++) push(32'hD000_0000 + 32'(i), 1'b1);
    push(32'hDEAD_BEEF, 1'b0);
    reg_rd(2'd3, rd);
    chk(rd[3:0] == 4'd8 && rd[9], "R12 full with overflow", rd, 32'h0000_0208);
    reg_wr(2'd3, 32'h0000_0200);
    reg_rd(2'd3, rd);
    chk(!rd[9] && rd[3:0] == 4'd8, "R12 overflow cleared", rd, 32'h0000_0008);
    reg_wr(2'd0, 32'd0);
    q_rd = q_wr;

    // random transfers
    for (int r = 0; r < 20; r++) begin
      cnt = $urandom_range(1, 12);
      base = $urandom;
      reg_wr(2'd1, base);
      reg_wr(2'd2, 32'(cnt));
      start_xfer(base, cnt);
      reg_wr(2'd0, ctrl_word(1'b1, 1'b1, 4'($urandom_range(0, 15))));
      pushed = 0;
      for (int i = 0; i < 3000 && xfer_writes < cnt; i++) begin
        if (pushed < cnt && lvl() < 8 && $urandom_range(0, 1) == 1) begin
          push($urandom, 1'b1);
          pushed++;
        end else tick();
      end
      repeat (3) tick();
      @(negedge clk);
      chk(!thresh_irq, "R9 masked in random run", 32'(thresh_irq), 32'd0);
      tick();
      chk(done_seen == 1, "R5 random completion", 32'(done_seen), 32'd1);
      reg_rd(2'd3, rd);
      chk(rd[31:16] == 16'd0 && !rd[8], "R13 status after completion", rd, 32'd0);
      reg_wr(2'd0, ctrl_word(1'b0, 1'b1, 4'd0));
    end

    rand_ready = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule